// File: doc/BRIEF.md
# Flash Command Mode Controller

This block sits behind the write side of a parallel NOR-style flash pin interface. It watches chip enable and write enable and takes one address/data pair each time a write cycle ends. It decodes multi-cycle command patterns from those pairs and tracks which operating mode the device is in. When a write is meant as program data, it issues a one-cycle program request, with the address and data, to a downstream array model.

There are two ways to program. The normal way needs a three-write command prefix before every data write. The second way is a six-write pattern that latches a single-pulse program mode. In that mode every later write is programmed as it stands, even a write that looks like a command. The latched mode clears only when power drops or when the device reset pin has been held low long enough and is then released. A cycle counter measures that reset width and also drives an output that qualifies the width. All inputs are asynchronous to the system clock and pass through two-stage synchronizers.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the system reset `rst_ni`, `mode_o` is 2'b00 (read), `prog_valid_o` is 0 and `rst_qual_o` is 0.
- R2: A write cycle ends when `ce_ni | we_ni` rises. After the writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), the next write gives exactly one `prog_valid_o` pulse of one cycle. The pulse carries that write's full address and data and is due on the third rising clock edge after the write ends. `mode_o` then returns to 2'b00.
- R3: A write in read mode that does not start a known pattern issues no program request, and `mode_o` stays 2'b00.
- R4: A write that does not match the expected step of a partly entered pattern sends the controller back to read mode (2'b00) and issues no program request. The data write that follows is not programmed.
- R5: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x40) set `mode_o` to 2'b10 (single-pulse). Each later write then gives one program pulse with its address and data.
- R6: In single-pulse mode, a write whose pair matches a command step is still programmed, and `mode_o` stays 2'b10.
- R7: `rst_qual_o` is high once the synchronized `dev_rst_ni` has been low for ceil(RST_MIN_NS*1000/CLK_PERIOD_PS) cycles. With the defaults this is 125 cycles, or 500 ns. Releasing the pin after that point returns `mode_o` to 2'b00.
- R8: A low pulse on `dev_rst_ni` that is too short leaves `rst_qual_o` at 0. It does not clear single-pulse mode, and later writes are still programmed.
- R9: When `power_ok_i` goes low, the controller returns to read mode, and single-pulse mode is cleared.
- R10: A write is ignored if it ends while `oe_ni` is low, while `dev_rst_ni` is low, or while `power_ok_i` is low. Holding `dev_rst_ni` low for any length of time also drops a partly entered pattern.
- R11: While a pattern is partly entered, or while the controller waits for the program data write, `mode_o` is 2'b01.
- R12: Only the low 11 address bits and the low 8 data bits are compared against the command patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| power_ok_i | input | 1 | High while supply power is good; low means power-down |
| dev_rst_ni | input | 1 | Device reset pin, active low, asynchronous |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| prog_valid_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Program address |
| prog_data_o | output | DATA_W | Program data |
| mode_o | output | 2 | 00 read, 01 command entry, 10 single-pulse program |
| rst_qual_o | output | 1 | Device reset has been held low long enough |

## Verification
Program pulses and mode changes from a write are due on the third rising clock edge after `ce_ni | we_ni` rises: two synchronizer stages, then the state register. The bench raises the strobe on a falling edge and samples on the third falling edge after it. It then checks one falling edge later that the pulse has cleared. The reset-width tests hold `dev_rst_ni` low for 100 or 130 cycles, which keeps clear of the 125-cycle threshold by more than the two-cycle synchronizer lag. Effects of the pin being released are checked four cycles later. A bench counter of program pulses shows that writes which should be ignored issued none.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEQ   = 2'd1,
    ST_PDATA = 2'd2,
    ST_SP    = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'b00,
    MODE_CMD  = 2'b01,
    MODE_SP   = 2'b10
  } fcc_mode_e;
endpackage

// File: rtl/fcc_sync.sv
`timescale 1ns/1ps
module fcc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) q[i] <= RST_VAL;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/fcc_rst_qual.sv
`timescale 1ns/1ps
module fcc_rst_qual #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int RST_MIN_NS    = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,     // synchronized device reset, active low
  output logic qual_o,
  output logic release_o
);
  localparam int RST_CYC = (RST_MIN_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int CNT_W   = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sat;

  assign sat = (cnt_q == CNT_W'(RST_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (pin_s_i)  cnt_q <= '0;
    else if (!sat)     cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o    = sat;
  // counter is nonzero only if the pin was low last cycle
  assign release_o = pin_s_i & sat;
endmodule

// File: rtl/fcc_seq.sv
`timescale 1ns/1ps
module fcc_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int CMD_AW   = 11,
  parameter int CMD_DW   = 8,
  parameter int PROG_LEN = 3,
  parameter int SP_LEN   = 6,
  parameter logic [PROG_LEN-1:0][CMD_AW-1:0] PROG_ADDR = '0,
  parameter logic [PROG_LEN-1:0][CMD_DW-1:0] PROG_DATA = '0,
  parameter logic [SP_LEN-1:0][CMD_AW-1:0]   SP_ADDR   = '0,
  parameter logic [SP_LEN-1:0][CMD_DW-1:0]   SP_DATA   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              abort_i,
  input  logic              sp_clr_i,
  output logic              prog_valid_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic [1:0]        mode_o
);
  localparam int SEQ_MAX = (PROG_LEN > SP_LEN) ? PROG_LEN : SP_LEN;
  localparam int IDX_W   = $clog2(SEQ_MAX + 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pa_q, pa_d, sa_q, sa_d;
  logic             pv_d;
  logic [PROG_LEN-1:0] p_match;
  logic [SP_LEN-1:0]   s_match;
  logic             p_hit, s_hit;

  for (genvar i = 0; i < PROG_LEN; i++) begin : g_pm
    assign p_match[i] = (wr_addr_i[CMD_AW-1:0] == PROG_ADDR[i]) &&
                        (wr_data_i[CMD_DW-1:0] == PROG_DATA[i]);
  end
  for (genvar i = 0; i < SP_LEN; i++) begin : g_sm
    assign s_match[i] = (wr_addr_i[CMD_AW-1:0] == SP_ADDR[i]) &&
                        (wr_data_i[CMD_DW-1:0] == SP_DATA[i]);
  end

  always_comb begin
    p_hit = 1'b0;
    s_hit = 1'b0;
    for (int i = 0; i < PROG_LEN; i++)
      if (idx_q == IDX_W'(i) && p_match[i]) p_hit = pa_q;
    for (int i = 0; i < SP_LEN; i++)
      if (idx_q == IDX_W'(i) && s_match[i]) s_hit = sa_q;
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    pa_d  = pa_q;
    sa_d  = sa_q;
    pv_d  = 1'b0;
    if (sp_clr_i || (abort_i && st_q != ST_SP)) begin
      st_d  = ST_IDLE;
      idx_d = '0;
      pa_d  = 1'b1;
      sa_d  = 1'b1;
    end else if (wr_evt_i) begin
      unique case (st_q)
        ST_SP:    pv_d = 1'b1;
        ST_PDATA: begin
          pv_d = 1'b1;
          st_d = ST_IDLE;
        end
        default: begin
          idx_d = '0;
          pa_d  = 1'b1;
          sa_d  = 1'b1;
          if (p_hit && idx_q == IDX_W'(PROG_LEN - 1)) begin
            st_d = ST_PDATA;
          end else if (s_hit && idx_q == IDX_W'(SP_LEN - 1)) begin
            st_d = ST_SP;
          end else if (p_hit || s_hit) begin
            st_d  = ST_SEQ;
            idx_d = idx_q + 1'b1;
            pa_d  = p_hit;
            sa_d  = s_hit;
          end else begin
            st_d = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      pa_q         <= 1'b1;
      sa_q         <= 1'b1;
      prog_valid_o <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
    end else begin
      st_q         <= st_d;
      idx_q        <= idx_d;
      pa_q         <= pa_d;
      sa_q         <= sa_d;
      prog_valid_o <= pv_d;
      if (pv_d) begin
        prog_addr_o <= wr_addr_i;
        prog_data_o <= wr_data_i;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:          mode_o = MODE_READ;
      ST_SEQ, ST_PDATA: mode_o = MODE_CMD;
      default:          mode_o = MODE_SP;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 16,
  parameter int CMD_AW        = 11,
  parameter int CMD_DW        = 8,
  parameter int PROG_LEN      = 3,
  parameter int SP_LEN        = 6,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int RST_MIN_NS    = 500,
  parameter logic [PROG_LEN-1:0][CMD_AW-1:0] PROG_ADDR = {11'h555, 11'h2AA, 11'h555},
  parameter logic [PROG_LEN-1:0][CMD_DW-1:0] PROG_DATA = {8'hA0, 8'h55, 8'hAA},
  parameter logic [SP_LEN-1:0][CMD_AW-1:0]   SP_ADDR   =
    {11'h555, 11'h2AA, 11'h555, 11'h555, 11'h2AA, 11'h555},
  parameter logic [SP_LEN-1:0][CMD_DW-1:0]   SP_DATA   =
    {8'h40, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              power_ok_i,
  input  logic              dev_rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_valid_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic [1:0]        mode_o,
  output logic              rst_qual_o
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic              wr_n_s, oe_n_s, dev_rst_s, pwr_s;
  logic              wr_n_d;
  logic              wr_edge, wr_evt;
  logic [BUS_W-1:0]  bus_s;
  logic              qual_rel;

  fcc_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1111)) u_ctl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ce_ni | we_ni, oe_ni, dev_rst_ni, power_ok_i}),
    .q_o    ({wr_n_s, oe_n_s, dev_rst_s, pwr_s})
  );

  // address/data delayed to line up with the strobe edge
  fcc_sync #(.W(BUS_W), .STAGES(2), .RST_VAL('0)) u_bus_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({addr_i, data_i}),
    .q_o    (bus_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_n_d <= 1'b1;
    else         wr_n_d <= wr_n_s;
  end

  assign wr_edge = wr_n_s & ~wr_n_d;
  assign wr_evt  = wr_edge & oe_n_s & dev_rst_s & pwr_s;

  fcc_rst_qual #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .RST_MIN_NS    (RST_MIN_NS)
  ) u_rst_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (dev_rst_s),
    .qual_o    (rst_qual_o),
    .release_o (qual_rel)
  );

  fcc_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_AW    (CMD_AW),
    .CMD_DW    (CMD_DW),
    .PROG_LEN  (PROG_LEN),
    .SP_LEN    (SP_LEN),
    .PROG_ADDR (PROG_ADDR),
    .PROG_DATA (PROG_DATA),
    .SP_ADDR   (SP_ADDR),
    .SP_DATA   (SP_DATA)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_evt_i     (wr_evt),
    .wr_addr_i    (bus_s[BUS_W-1:DATA_W]),
    .wr_data_i    (bus_s[DATA_W-1:0]),
    .abort_i      (~dev_rst_s),
    .sp_clr_i     (qual_rel | ~pwr_s),
    .prog_valid_o (prog_valid_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .mode_o       (mode_o)
  );
endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       power_ok_i,
  input logic       pwr_s,
  input logic       prog_valid_o,
  input logic [1:0] mode_o,
  input logic       rst_qual_o
);
  assert_prog_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |=> !prog_valid_o);

  assert_no_prog_from_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> $past(mode_o) != MODE_READ);

  assert_sp_exit_qualified_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == MODE_SP && mode_o != MODE_SP) |-> ($past(rst_qual_o) || !$past(pwr_s)));

  assert_power_down_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!power_ok_i && !$past(power_ok_i) && !$past(power_ok_i, 2)) |=> mode_o == MODE_READ);

  assert_prog_needs_power_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> $past(pwr_s));
endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .power_ok_i   (power_ok_i),
  .pwr_s        (pwr_s),
  .prog_valid_o (prog_valid_o),
  .mode_o       (mode_o),
  .rst_qual_o   (rst_qual_o)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        power_ok = 1'b1;
  logic        dev_rst_n = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [20:0] addr = '0;
  logic [15:0] data = '0;
  logic        prog_valid;
  logic [20:0] prog_addr;
  logic [15:0] prog_data;
  logic [1:0]  mode;
  logic        rst_qual;

  int checks = 0, errors = 0, n_prog = 0;
  bit done = 0;
  logic        obs_pv, obs_pv2;
  logic [20:0] obs_a;
  logic [15:0] obs_d;
  logic [1:0]  obs_m;

  always #2 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .power_ok_i(power_ok), .dev_rst_ni(dev_rst_n),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .data_i(data),
    .prog_valid_o(prog_valid), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .mode_o(mode), .rst_qual_o(rst_qual)
  );

  always @(negedge clk) if (rst_n && prog_valid) n_prog++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d, input bit oe_low = 0);
    @(negedge clk);
    addr = a; data = d; oe_n = !oe_low; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    obs_pv = prog_valid; obs_a = prog_addr; obs_d = prog_data; obs_m = mode;
    @(negedge clk);
    obs_pv2 = prog_valid;
    oe_n = 1'b1;
  endtask

  task automatic wr_prefix();
    wr(21'h555, 16'hAA);
    wr(21'h2AA, 16'h55);
    wr(21'h555, 16'hA0);
  endtask

  task automatic wr_sp_entry();
    wr(21'h555, 16'hAA); wr(21'h2AA, 16'h55); wr(21'h555, 16'h80);
    wr(21'h555, 16'hAA); wr(21'h2AA, 16'h55); wr(21'h555, 16'h40);
  endtask

  task automatic pulse_dev_rst(input int cyc, output logic q);
    @(negedge clk);
    dev_rst_n = 1'b0;
    repeat (cyc) @(negedge clk);
    q = rst_qual;
    dev_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 2'b00);
    chk("R1 prog_valid", prog_valid, 0);
    chk("R1 rst_qual", rst_qual, 0);
  endtask

  task automatic t_plain_write();
    int n0 = n_prog;
    wr(21'h0123, 16'h5A5A);
    chk("R3 no program", n_prog - n0, 0);
    chk("R3 mode", obs_m, 2'b00);
  endtask

  task automatic t_normal_prog();
    int n0 = n_prog;
    wr(21'h555, 16'hAA);
    chk("R11 mode after first step", obs_m, 2'b01);
    wr(21'h2AA, 16'h55);
    wr(21'h555, 16'hA0);
    chk("R11 mode awaiting data", obs_m, 2'b01);
    chk("R2 no pulse during prefix", n_prog - n0, 0);
    wr(21'h1ABCD, 16'hC3E1);
    chk("R2 pulse due", obs_pv, 1);
    chk("R2 addr", obs_a, 21'h1ABCD);
    chk("R2 data", obs_d, 16'hC3E1);
    chk("R2 pulse one cycle", obs_pv2, 0);
    chk("R2 mode back to read", obs_m, 2'b00);
    chk("R2 pulse count", n_prog - n0, 1);
  endtask

  task automatic t_mismatch();
    int n0 = n_prog;
    wr(21'h555, 16'hAA);
    wr(21'h2AA, 16'h55);
    wr(21'h555, 16'h11);
    chk("R4 mode after mismatch", obs_m, 2'b00);
    wr(21'h0777, 16'h7777);
    chk("R4 no program", n_prog - n0, 0);
  endtask

  task automatic t_high_addr_bits();
    int n0 = n_prog;
    wr(21'h1F555, 16'hFFAA);
    wr(21'h0A2AA, 16'h1255);
    wr(21'h10555, 16'h00A0);
    wr(21'h00042, 16'h4242);
    chk("R12 upper bits ignored", n_prog - n0, 1);
    chk("R12 data", obs_d, 16'h4242);
  endtask

  task automatic t_oe_ignored();
    int n0 = n_prog;
    wr(21'h555, 16'hAA);
    wr(21'h2AA, 16'h55, 1);
    chk("R10 oe write ignored keeps step", obs_m, 2'b01);
    wr(21'h2AA, 16'h55);
    wr(21'h555, 16'hA0);
    wr(21'h0300, 16'h0BEE, 1);
    chk("R10 data write under oe ignored", n_prog - n0, 0);
    wr(21'h0301, 16'h0CAF);
    chk("R10 later data programmed", n_prog - n0, 1);
    chk("R10 addr", obs_a, 21'h0301);
  endtask

  task automatic t_dev_rst_abort();
    int n0 = n_prog;
    logic q;
    wr(21'h555, 16'hAA);
    wr(21'h2AA, 16'h55);
    pulse_dev_rst(10, q);
    chk("R10 reset drops pattern", mode, 2'b00);
    wr(21'h555, 16'hA0);
    wr(21'h0400, 16'h4444);
    chk("R10 no program after abort", n_prog - n0, 0);
  endtask

  task automatic t_sp_mode();
    int n0 = n_prog;
    wr_sp_entry();
    chk("R5 mode single-pulse", obs_m, 2'b10);
    chk("R5 no pulse during entry", n_prog - n0, 0);
    wr(21'h01234, 16'hBEEF);
    chk("R5 pulse", obs_pv, 1);
    chk("R5 addr", obs_a, 21'h01234);
    chk("R5 data", obs_d, 16'hBEEF);
    wr(21'h555, 16'hAA);
    chk("R6 command pair programmed", obs_pv, 1);
    chk("R6 data", obs_d, 16'h00AA);
    wr(21'h555, 16'hA0);
    chk("R6 mode held", obs_m, 2'b10);
    chk("R6 pulse count", n_prog - n0, 3);
  endtask

  task automatic t_short_rst();
    logic q;
    pulse_dev_rst(100, q);
    chk("R8 qual stays low", q, 0);
    chk("R8 mode kept", mode, 2'b10);
    wr(21'h00777, 16'h1357);
    chk("R8 still programs", obs_pv, 1);
    chk("R8 data", obs_d, 16'h1357);
  endtask

  task automatic t_long_rst();
    logic q;
    int n0;
    pulse_dev_rst(130, q);
    chk("R7 qual high", q, 1);
    chk("R7 mode cleared", mode, 2'b00);
    chk("R7 qual low after release", rst_qual, 0);
    n0 = n_prog;
    wr(21'h00888, 16'h2468);
    chk("R7 read mode write not programmed", n_prog - n0, 0);
  endtask

  task automatic t_power();
    int n0;
    wr_sp_entry();
    chk("R5 re-entered", obs_m, 2'b10);
    @(negedge clk);
    power_ok = 1'b0;
    repeat (3) @(negedge clk);
    n0 = n_prog;
    wr(21'h00999, 16'h9999);
    chk("R10 write ignored at power-down", n_prog - n0, 0);
    power_ok = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 mode read after power-down", mode, 2'b00);
    wr(21'h00AAA, 16'h1111);
    chk("R9 single-pulse cleared", n_prog - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain_write();
    t_normal_prog();
    t_mismatch();
    t_high_addr_bits();
    t_oe_ignored();
    t_dev_rst_abort();
    t_sp_mode();
    t_short_rst();
    t_long_rst();
    t_power();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule